// File: doc/BRIEF.md
# Direct-Mapped Address Translator with Hardware Page-Table Walk

This block turns a 32-bit byte virtual address into a 32-bit physical address for a single requester. Pages are 4 KB, so the low 12 address bits pass through unchanged. The upper 20 bits, the virtual page number, are looked up in a 16-entry direct-mapped translation buffer. The low four page-number bits pick one entry, and the remaining sixteen bits are compared against that entry's stored tag. On a hit, the answer comes back one cycle after the request is accepted, and no memory access is made.

On a miss, the block fetches one 32-bit page-table entry through a read port with a ready/valid handshake. The address of that entry is the page-table base input plus four times the virtual page number. The block then checks the entry's present and writable flags. If the walk succeeds, it overwrites the indexed buffer entry and responds in the cycle after the memory data arrives. A walk that ends in a fault leaves the buffer untouched.

The block takes only one request at a time, and `req_ready` stays low while a walk is running. A flush input invalidates every entry in a single cycle.

Top module: `xlt_top`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1 and both `rsp_valid` and `mem_rd_valid` are 0. All buffer entries are invalid, so the first access to any page walks the table.
- R2: On a hit, `rsp_valid` rises in the first cycle after the request is accepted. `rsp_paddr` is then the stored 20-bit physical page number in bits 31:12 with the request's bits 11:0 below it, and no memory read is issued.
- R3: On a miss, `mem_rd_addr` equals `pt_base` + (virtual page number × 4). `mem_rd_valid` stays high with a stable address until `mem_rd_ready` is seen.
- R4: A page-table entry uses bit 31 as present, bit 30 as writable and bits 19:0 as the physical page number. A successful walk returns {page number, offset} in the cycle after `mem_rsp_valid`, and it fills the indexed entry so that a later access to the same page hits.
- R5: A walk that reads an entry with bit 31 clear reports `rsp_page_fault` and does not fill the buffer, so a repeated access walks again.
- R6: A write request whose walked entry has bit 31 set and bit 30 clear reports `rsp_prot_fault` and does not fill the buffer. A read to the same page then walks and succeeds.
- R7: A write that hits an entry filled as read-only reports `rsp_prot_fault` without any memory read. A read that hits the same entry translates normally.
- R8: Two pages whose page numbers share bits 3:0 evict each other. Entries at other indices are not disturbed.
- R9: A one-cycle `flush` invalidates all entries. A request accepted in the same cycle as `flush` is treated as a miss.
- R10: `req_ready` is 0 from the cycle after a miss is accepted until the response, and `rsp_valid` is a one-cycle pulse. The two fault flags are never set together.
- R11: When either fault flag is set, `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all buffer entries |
| pt_base | input | 32 | Byte address of the page table |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | Request is a write |
| req_vaddr | input | 32 | Virtual byte address |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical byte address (0 on a fault) |
| rsp_page_fault | output | 1 | Page not present |
| rsp_prot_fault | output | 1 | Write to a read-only page |
| mem_rd_valid | output | 1 | Page-table read request |
| mem_rd_addr | output | 32 | Page-table entry address |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Page-table entry word |

## Verification
The embedded properties cover the behaviours that hold on every cycle:
- the read request holding steady under back-pressure;
- `req_ready` staying low while a read is outstanding;
- the two fault flags being exclusive, with a zero address on any fault;
- the response offset matching the captured request;
- the buffer being empty the cycle after a flush.

Only the directed scenarios can show the behaviours that depend on history, because they need a sequence of requests and a count of memory reads. These are:
- hits that follow a fill;
- faulting walks that leave no entry behind;
- eviction between pages that share an index;
- hits on read-only entries that issue no memory access;
- a request that coincides with a flush.

// File: rtl/xlt_pkg.sv
// Shared constants and types for the address translator.
// Assumes page-table entries are one 32-bit word.
package xlt_pkg;
    localparam int PTE_PRESENT_BIT  = 31;
    localparam int PTE_WRITABLE_BIT = 30;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_ISSUE = 2'd1,
        WK_WAIT  = 2'd2
    } walk_state_e;
endpackage

// File: rtl/xlt_tlb_store.sv
// Direct-mapped translation storage: one entry per low-VPN index.
// Lookup is combinational. The fill writes at the clock edge.
// A flush clears every valid bit, takes priority over a fill, and masks
// lookups in the same cycle.
module xlt_tlb_store #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic [ADDR_W-OFF_W-1:0]   lk_vpn,
    output logic                      lk_hit,
    output logic [ADDR_W-OFF_W-1:0]   lk_ppn,
    output logic                      lk_writable,
    input  logic                      fill_en,
    input  logic [ADDR_W-OFF_W-1:0]   fill_vpn,
    input  logic [ADDR_W-OFF_W-1:0]   fill_ppn,
    input  logic                      fill_writable
);
    localparam int VPN_W = ADDR_W - OFF_W;
    localparam int PPN_W = ADDR_W - OFF_W;
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld_vec;
    logic [DEPTH-1:0] wr_vec;
    logic [TAG_W-1:0] tag_arr [DEPTH];
    logic [PPN_W-1:0] ppn_arr [DEPTH];

    logic [IDX_W-1:0] lk_idx, fill_idx;
    logic [TAG_W-1:0] lk_tag;

    assign lk_idx   = lk_vpn[IDX_W-1:0];
    assign lk_tag   = lk_vpn[VPN_W-1:IDX_W];
    assign fill_idx = fill_vpn[IDX_W-1:0];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic             v_q;
        logic             w_q;
        logic [TAG_W-1:0] t_q;
        logic [PPN_W-1:0] p_q;

        // Valid bit: cleared by reset or flush, set by a fill to this index.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                v_q <= 1'b0;
            end else if (fill_en && fill_idx == IDX_W'(g)) begin
                v_q <= 1'b1;
            end
        end

        // Payload: tag, page number and writable flag written on a fill.
        always_ff @(posedge clk) begin
            if (fill_en && fill_idx == IDX_W'(g)) begin
                t_q <= fill_vpn[VPN_W-1:IDX_W];
                p_q <= fill_ppn;
                w_q <= fill_writable;
            end
        end

        assign vld_vec[g] = v_q;
        assign wr_vec[g]  = w_q;
        assign tag_arr[g] = t_q;
        assign ppn_arr[g] = p_q;
    end

    // Lookup: an entry hits only when it is valid, its tag matches, and no
    // flush is under way.
    always_comb begin
        lk_hit      = vld_vec[lk_idx] && (tag_arr[lk_idx] == lk_tag) && !flush;
        lk_ppn      = ppn_arr[lk_idx];
        lk_writable = wr_vec[lk_idx];
    end

    // R9: a flush leaves no valid entry behind.
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_vec == '0));
endmodule

// File: rtl/xlt_walker.sv
// Single-level page-table walker. It forms the entry address
// base + (vpn << 2), issues one read with a ready/valid handshake, and
// reports the entry fields when the data returns. It assumes one read
// outstanding at a time and at least one cycle of read latency.
module xlt_walker
    import xlt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [ADDR_W-OFF_W-1:0] start_vpn,
    input  logic [ADDR_W-1:0]       pt_base,
    output logic                    mem_rd_valid,
    output logic [ADDR_W-1:0]       mem_rd_addr,
    input  logic                    mem_rd_ready,
    input  logic                    mem_rsp_valid,
    input  logic [31:0]             mem_rsp_data,
    output logic                    busy,
    output logic                    done,
    output logic                    pte_present,
    output logic                    pte_writable,
    output logic [ADDR_W-OFF_W-1:0] pte_ppn
);
    localparam int VPN_W = ADDR_W - OFF_W;
    localparam int PPN_W = ADDR_W - OFF_W;
    localparam int PAD_W = ADDR_W - VPN_W - 2;

    walk_state_e       state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              unused_pte_bits;

    // Walk sequencing: idle, then issue the read, then wait for the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WK_IDLE;
        end else begin
            case (state_q)
                WK_IDLE:  if (start)         state_q <= WK_ISSUE;
                WK_ISSUE: if (mem_rd_ready)  state_q <= WK_WAIT;
                WK_WAIT:  if (mem_rsp_valid) state_q <= WK_IDLE;
                default:                     state_q <= WK_IDLE;
            endcase
        end
    end

    // Entry address: captured when a walk starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (start && state_q == WK_IDLE) begin
            addr_q <= pt_base + {{PAD_W{1'b0}}, start_vpn, 2'b00};
        end
    end

    assign mem_rd_valid    = (state_q == WK_ISSUE);
    assign mem_rd_addr     = addr_q;
    assign busy            = (state_q != WK_IDLE);
    assign done            = (state_q == WK_WAIT) && mem_rsp_valid;
    assign pte_present     = mem_rsp_data[PTE_PRESENT_BIT];
    assign pte_writable    = mem_rsp_data[PTE_WRITABLE_BIT];
    assign pte_ppn         = mem_rsp_data[PPN_W-1:0];
    assign unused_pte_bits = ^mem_rsp_data[PTE_WRITABLE_BIT-1:PPN_W];

    // R3: a read under back-pressure holds its request and address.
    p_read_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
endmodule

// File: rtl/xlt_top.sv
// Virtual-to-physical translator: a direct-mapped buffer lookup with an
// in-hardware walk on a miss, plus a permission check on writes. It takes
// one request at a time. Hits answer one cycle after acceptance; walks
// answer one cycle after the page-table data returns.
module xlt_top #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] pt_base,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_vaddr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_page_fault,
    output logic              rsp_prot_fault,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ready,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data
);
    localparam int VPN_W = ADDR_W - OFF_W;
    localparam int PPN_W = ADDR_W - OFF_W;

    logic              accept, walk_busy, walk_done, start_walk, hit_ok;
    logic              lk_hit, lk_writable;
    logic [PPN_W-1:0]  lk_ppn, pte_ppn;
    logic              pte_present, pte_writable;
    logic              walk_pf, walk_pr, fill_en;
    logic [ADDR_W-1:0] cur_vaddr;
    logic              cur_write;

    assign req_ready  = !walk_busy;
    assign accept     = req_valid && req_ready;
    assign hit_ok     = accept && lk_hit;
    assign start_walk = accept && !lk_hit;
    assign walk_pf    = walk_done && !pte_present;
    assign walk_pr    = walk_done && pte_present && cur_write && !pte_writable;
    assign fill_en    = walk_done && pte_present && !walk_pr;

    xlt_tlb_store #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (flush),
        .lk_vpn        (req_vaddr[ADDR_W-1:OFF_W]),
        .lk_hit        (lk_hit),
        .lk_ppn        (lk_ppn),
        .lk_writable   (lk_writable),
        .fill_en       (fill_en),
        .fill_vpn      (cur_vaddr[ADDR_W-1:OFF_W]),
        .fill_ppn      (pte_ppn),
        .fill_writable (pte_writable)
    );

    xlt_walker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start_walk),
        .start_vpn     (req_vaddr[ADDR_W-1:OFF_W]),
        .pt_base       (pt_base),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .busy          (walk_busy),
        .done          (walk_done),
        .pte_present   (pte_present),
        .pte_writable  (pte_writable),
        .pte_ppn       (pte_ppn)
    );

    // Request capture: hold the address and direction for the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_vaddr <= '0;
            cur_write <= 1'b0;
        end else if (accept) begin
            cur_vaddr <= req_vaddr;
            cur_write <= req_write;
        end
    end

    // Response register: a one-cycle pulse from either a hit or a walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_paddr      <= '0;
            rsp_page_fault <= 1'b0;
            rsp_prot_fault <= 1'b0;
        end else begin
            rsp_valid      <= hit_ok || walk_done;
            rsp_page_fault <= walk_pf;
            rsp_prot_fault <= walk_pr || (hit_ok && req_write && !lk_writable);
            if (hit_ok) begin
                rsp_paddr <= (req_write && !lk_writable) ? '0
                           : {lk_ppn, req_vaddr[OFF_W-1:0]};
            end else if (fill_en) begin
                rsp_paddr <= {pte_ppn, cur_vaddr[OFF_W-1:0]};
            end else begin
                rsp_paddr <= '0;
            end
        end
    end

    // R10: no new request is taken while a table read is pending.
    p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready);

    // R10: the fault kinds are exclusive and appear only with a response.
    p_fault_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_page_fault || rsp_prot_fault) |-> (rsp_valid && !(rsp_page_fault && rsp_prot_fault)));

    // R11: a faulting response carries a zero address.
    p_fault_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_page_fault || rsp_prot_fault)) |-> (rsp_paddr == '0));

    // R2: a good response keeps the request's page offset.
    p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_page_fault && !rsp_prot_fault)
            |-> (rsp_paddr[OFF_W-1:0] == cur_vaddr[OFF_W-1:0]));

    // R4: a walk that fills the buffer ends with a response next cycle.
    p_fill_responds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (rsp_valid && !rsp_page_fault && !rsp_prot_fault));
endmodule

// File: tb/tb_xlt_top.sv
`timescale 1ns/1ps
module tb_xlt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] pt_base = 32'h0010_0000;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready, rsp_valid, rsp_page_fault, rsp_prot_fault;
    logic [31:0] rsp_paddr, mem_rd_addr;
    logic        mem_rd_valid, mem_rd_ready;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    xlt_top dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
        .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_page_fault(rsp_page_fault), .rsp_prot_fault(rsp_prot_fault),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    // Page-table memory model.
    logic [31:0] pt_mem [logic [31:0]];
    int          stall = 0;
    int          wait_cnt = 0;
    int          rd_count = 0;
    logic [31:0] last_addr = '0;
    logic [31:0] pend_addr = '0;
    bit          pend = 0;
    int          pend_cnt = 0;

    assign mem_rd_ready = mem_rd_valid && (wait_cnt >= stall);

    always @(posedge clk) begin
        if (mem_rd_valid && !mem_rd_ready) wait_cnt <= wait_cnt + 1;
        else                                wait_cnt <= 0;
        mem_rsp_valid <= 1'b0;
        if (pend) begin
            if (pend_cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= pt_mem.exists(pend_addr) ? pt_mem[pend_addr] : 32'h0;
                pend <= 0;
            end else begin
                pend_cnt <= pend_cnt - 1;
            end
        end
        if (mem_rd_valid && mem_rd_ready) begin
            pend      <= 1;
            pend_cnt  <= 1;
            pend_addr <= mem_rd_addr;
            last_addr <= mem_rd_addr;
            rd_count  <= rd_count + 1;
        end
    end

    function automatic logic [31:0] pte_addr(input logic [19:0] vpn);
        return pt_base + {10'b0, vpn, 2'b00};
    endfunction

    task automatic set_pte(input logic [19:0] vpn, input bit pres, input bit wr,
                           input logic [19:0] ppn);
        pt_mem[pte_addr(vpn)] = {pres, wr, 10'b0, ppn};
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One translation; returns response fields, cycles to response, and
    // whether req_ready was seen high while waiting.
    task automatic xlate(input logic [31:0] va, input bit wr, input bit with_flush,
                         output logic [31:0] pa, output bit pf, output bit pr,
                         output int lat, output bit rdy_seen, output bit pulse_ok);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; flush = with_flush;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; flush = 1'b0;
        lat = 1; rdy_seen = 0;
        while (!rsp_valid && lat < 200) begin
            if (req_ready) rdy_seen = 1;
            @(negedge clk);
            lat++;
        end
        pa = rsp_paddr; pf = rsp_page_fault; pr = rsp_prot_fault;
        @(negedge clk);
        pulse_ok = !rsp_valid;
    endtask

    logic [31:0] pa;
    bit pf, pr, rs, po;
    int lat, r0;

    task automatic t_reset;
        chk(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk(mem_rd_valid == 1'b0, "R1 mem_rd_valid after reset", 32'(mem_rd_valid), 32'd0);
    endtask

    task automatic t_miss_then_hit;
        set_pte(20'h12345, 1, 1, 20'h0ABCD);
        r0 = rd_count;
        xlate(32'h1234_5ABC, 0, 0, pa, pf, pr, lat, rs, po);
        chk(rd_count == r0 + 1, "R1 first access walks", rd_count, r0 + 1);
        chk(last_addr == pte_addr(20'h12345), "R3 entry address", last_addr, pte_addr(20'h12345));
        chk(pa == 32'h0ABC_DABC && !pf && !pr, "R4 walked address", pa, 32'h0ABC_DABC);
        chk(!rs, "R10 ready low during walk", 32'(rs), 32'd0);
        chk(po, "R10 single-cycle response", 32'(po), 32'd1);
        r0 = rd_count;
        xlate(32'h1234_5123, 1, 0, pa, pf, pr, lat, rs, po);
        chk(pa == 32'h0ABC_D123 && !pf && !pr, "R2 hit address", pa, 32'h0ABC_D123);
        chk(lat == 1, "R2 hit latency", lat, 1);
        chk(rd_count == r0, "R2 hit makes no read", rd_count, r0);
    endtask

    task automatic t_page_fault;
        r0 = rd_count;
        xlate(32'h0000_7010, 0, 0, pa, pf, pr, lat, rs, po);
        chk(pf && !pr, "R5 page fault flagged", {pf, pr}, 2'b10);
        chk(pa == 32'h0, "R11 zero address on fault", pa, 32'h0);
        xlate(32'h0000_7010, 0, 0, pa, pf, pr, lat, rs, po);
        chk(rd_count == r0 + 2, "R5 fault not cached", rd_count, r0 + 2);
    endtask

    task automatic t_protection;
        set_pte(20'h00400, 1, 0, 20'h00777);
        r0 = rd_count;
        xlate(32'h0040_0008, 1, 0, pa, pf, pr, lat, rs, po);
        chk(pr && !pf && pa == 0, "R6 walk write to read-only", {pf, pr}, 2'b01);
        xlate(32'h0040_0008, 0, 0, pa, pf, pr, lat, rs, po);
        chk(rd_count == r0 + 2, "R6 faulting walk left no entry", rd_count, r0 + 2);
        chk(pa == 32'h0077_7008 && !pf && !pr, "R6 read after fault", pa, 32'h0077_7008);
        r0 = rd_count;
        xlate(32'h0040_0FFC, 1, 0, pa, pf, pr, lat, rs, po);
        chk(pr && !pf && pa == 0, "R7 hit write to read-only", {pf, pr}, 2'b01);
        chk(rd_count == r0 && lat == 1, "R7 no read for hit fault", rd_count, r0);
        xlate(32'h0040_0FFC, 0, 0, pa, pf, pr, lat, rs, po);
        chk(pa == 32'h0077_7FFC && !pr, "R7 read hit on read-only", pa, 32'h0077_7FFC);
    endtask

    task automatic t_conflict;
        set_pte(20'h12355, 1, 1, 20'h00321);
        r0 = rd_count;
        xlate(32'h1235_5004, 0, 0, pa, pf, pr, lat, rs, po);
        chk(pa == 32'h0032_1004 && rd_count == r0 + 1, "R8 conflicting page walks", pa, 32'h0032_1004);
        xlate(32'h1234_5004, 0, 0, pa, pf, pr, lat, rs, po);
        chk(rd_count == r0 + 2, "R8 evicted page walks again", rd_count, r0 + 2);
        chk(pa == 32'h0ABC_D004, "R8 refetched address", pa, 32'h0ABC_D004);
        xlate(32'h0040_0010, 0, 0, pa, pf, pr, lat, rs, po);
        chk(rd_count == r0 + 2 && pa == 32'h0077_7010, "R8 other index kept", rd_count, r0 + 2);
    endtask

    task automatic t_flush;
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        r0 = rd_count;
        xlate(32'h1234_5000, 0, 0, pa, pf, pr, lat, rs, po);
        chk(rd_count == r0 + 1 && pa == 32'h0ABC_D000, "R9 flush then miss", rd_count, r0 + 1);
        xlate(32'h0040_0020, 0, 0, pa, pf, pr, lat, rs, po);
        r0 = rd_count;
        xlate(32'h0040_0020, 0, 1, pa, pf, pr, lat, rs, po);
        chk(rd_count == r0 + 1, "R9 request with flush misses", rd_count, r0 + 1);
        chk(pa == 32'h0077_7020, "R9 address after flush walk", pa, 32'h0077_7020);
    endtask

    task automatic t_stall;
        set_pte(20'h0ABCD, 1, 1, 20'hFEDCB);
        stall = 3;
        xlate(32'h0ABC_D55A, 1, 0, pa, pf, pr, lat, rs, po);
        chk(pa == 32'hFEDC_B55A && !pf && !pr, "R3 walk under back-pressure", pa, 32'hFEDC_B55A);
        chk(last_addr == pte_addr(20'h0ABCD), "R3 held entry address", last_addr, pte_addr(20'h0ABCD));
        stall = 0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss_then_hit();
        t_page_fault();
        t_protection();
        t_conflict();
        t_flush();
        t_stall();
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule